// File: doc/BRIEF.md
# Clock Generator Configuration Serial Slave

This block is the two-wire serial configuration port of a clock generator. It stores six 8-bit control bytes that gate and select the generator's output clocks, and it presents them as one flat bus to the rest of the chip. A faster system clock samples the serial clock and data lines through synchronizers, so all protocol logic runs in a single clock domain. The slave drives the data line only through an open-drain pull-down enable.

There is no register pointer. Every write carries a command byte and a count byte that are acknowledged and thrown away, after which data fills byte 0, byte 1 and upward. A read first returns a byte count of six and then the stored bytes from byte 0 up. The host may stop after any complete byte; bytes beyond the end are accepted and dropped on a write and read back as 0xFF.

Top module: `cfg_serial_slave`

## Requirements
- R1: The slave acknowledges (pulls data low in the ninth clock) the 8-bit address 0xD2 for writes and 0xD3 for reads.
- R2: After an address that is neither 0xD2 nor 0xD3 the slave gives no acknowledge and leaves the bus and all bytes untouched until the next start.
- R3: In a write, the first two bytes after the address are acknowledged and change no configuration byte.
- R4: Write data bytes land in byte 0, then byte 1 and so on, each acknowledged; byte k appears on `cfg_o[8k+7:8k]`.
- R5: A stop after any complete byte keeps the bytes already written and leaves the remaining bytes at their previous values.
- R6: Write bytes past byte 5 are acknowledged and discarded.
- R7: A read returns first the count 6 and then bytes 0 to 5 in order, most significant bit first.
- R8: A read that continues past byte 5 returns 0xFF for each further byte.
- R9: Reset sets byte 0 to 0x00, byte 1 to 0x1F, bytes 2, 3 and 5 to 0xFF and byte 4 to 0xEB, with the data line released.
- R10: A host not-acknowledge during a read makes the slave release the data line for the rest of the transfer.
- R11: Start is a falling data line and stop a rising data line while the serial clock is high; a repeated start restarts address decoding, and the data line only changes drive while the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| cfg_o | output | 48 | Configuration bytes, byte k at bits 8k+7:8k |

## Verification
The hardest situation to reach is a read that runs past the last stored byte and is then ended by a host not-acknowledge, because it needs a full frame of address, count and six data bytes before the overrun bytes and the release of the line become visible. The bench drives complete bit-level frames with a host model on a wired-AND data line and reads eight data bytes in one frame, not-acknowledging the last. A repeated start between a short write and a read, without a stop, checks that the written byte is retained and that addressing restarts.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WR, ST_RD} cfg_st_e;
  localparam logic [6:0] DEV_ADDR7 = 7'h69;
endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] chain_q [2];
  logic scl_q, sda_q;
  logic [1:0] raw;
  assign raw = {sda_i, scl_i};

  for (genvar l = 0; l < 2; l++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[l] <= '1;
      else         chain_q[l] <= {chain_q[l][STAGES-2:0], raw[l]};
    end
  end

  assign scl_s_o = chain_q[0][STAGES-1];
  assign sda_s_o = chain_q[1][STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_o;
      sda_q <= sda_s_o;
    end
  end

  assign scl_rise_o = scl_s_o & ~scl_q;
  assign scl_fall_o = ~scl_s_o & scl_q;
  assign start_o    = scl_s_o & scl_q & sda_q & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_q & ~sda_q & sda_s_o;
endmodule

// File: rtl/cfg_serial_fsm.sv
module cfg_serial_fsm
  import cfg_serial_pkg::*;
#(
  parameter int         NUM_BYTES = 6,
  parameter logic [6:0] ADDR7     = DEV_ADDR7,
  localparam int        IW        = $clog2(NUM_BYTES + 3) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_s_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [7:0]    rd_byte_i,
  output logic [IW-1:0] idx_o,
  output logic          sda_oe_o,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [7:0]    wr_data_o,
  output cfg_st_e       state_o
);
  cfg_st_e       state_q;
  logic [3:0]    bit_q;
  logic [7:0]    sh_q;
  logic [IW-1:0] idx_q;
  logic          oe_q;
  logic          data_slot;

  // index 0 = command, 1 = count, 2.. = data
  assign data_slot = (idx_q >= IW'(2)) && (idx_q < IW'(NUM_BYTES + 2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_q     <= '0;
      sh_q      <= '0;
      idx_q     <= '0;
      oe_q      <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        bit_q   <= '0;
        idx_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise_i && bit_q < 4'd8) begin
              sh_q  <= {sh_q[6:0], sda_s_i};
              bit_q <= bit_q + 4'd1;
            end
            if (scl_fall_i && bit_q == 4'd8) begin
              bit_q <= 4'd9;
              if (state_q == ST_ADDR) begin
                if (sh_q == {ADDR7, 1'b0}) begin
                  oe_q <= 1'b1; state_q <= ST_WR;
                end else if (sh_q == {ADDR7, 1'b1}) begin
                  oe_q <= 1'b1; state_q <= ST_RD;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                oe_q <= 1'b1;
                if (idx_q != '1) idx_q <= idx_q + IW'(1);
                if (data_slot) begin
                  wr_en_o   <= 1'b1;
                  wr_idx_o  <= idx_q - IW'(2);
                  wr_data_o <= sh_q;
                end
              end
            end
            if (scl_fall_i && bit_q == 4'd9) begin
              oe_q  <= 1'b0;
              bit_q <= '0;
            end
          end
          ST_RD: begin
            if (scl_rise_i) begin
              if (bit_q < 4'd8) bit_q <= bit_q + 4'd1;
              else if (bit_q == 4'd9 && sda_s_i) state_q <= ST_IDLE;
            end
            if (scl_fall_i) begin
              if (bit_q == 4'd8) begin
                oe_q  <= 1'b0;
                bit_q <= 4'd9;
              end else if (bit_q == 4'd9) begin
                sh_q  <= rd_byte_i;
                oe_q  <= ~rd_byte_i[7];
                bit_q <= '0;
                if (idx_q != '1) idx_q <= idx_q + IW'(1);
              end else if (bit_q != 4'd0) begin
                oe_q <= ~sh_q[3'd7 - bit_q[2:0]];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign idx_o    = idx_q;
  assign sda_oe_o = oe_q;
  assign state_o  = state_q;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int                     NUM_BYTES = 6,
  parameter logic [NUM_BYTES*8-1:0] RST_VAL   = '0,
  localparam int                    IW        = $clog2(NUM_BYTES + 3) + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [IW-1:0]          wr_idx_i,
  input  logic [7:0]             wr_data_i,
  output logic [NUM_BYTES*8-1:0] cfg_o
);
  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              cfg_o[8*k +: 8] <= RST_VAL[8*k +: 8];
      else if (wr_en_i && wr_idx_i == IW'(k))   cfg_o[8*k +: 8] <= wr_data_i;
    end
  end
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
  import cfg_serial_pkg::*;
#(
  parameter int                     NUM_BYTES = 6,
  parameter logic [6:0]             ADDR7     = DEV_ADDR7,
  parameter logic [NUM_BYTES*8-1:0] RST_VAL   = 48'hFF_EB_FF_FF_1F_00
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  output logic [NUM_BYTES*8-1:0] cfg_o
);
  localparam int IW = $clog2(NUM_BYTES + 3) + 1;

  logic          scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [IW-1:0] idx, wr_idx;
  logic [7:0]    rd_byte, wr_data;
  logic          wr_en;
  cfg_st_e       state;

  cfg_line_sync #(.STAGES(2)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_s_o(scl_s), .sda_s_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_evt), .stop_o(stop_evt)
  );

  cfg_serial_fsm #(.NUM_BYTES(NUM_BYTES), .ADDR7(ADDR7)) i_fsm (
    .clk_i, .rst_ni, .sda_s_i(sda_s), .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall), .start_i(start_evt), .stop_i(stop_evt),
    .rd_byte_i(rd_byte), .idx_o(idx), .sda_oe_o, .wr_en_o(wr_en),
    .wr_idx_o(wr_idx), .wr_data_o(wr_data), .state_o(state)
  );

  cfg_reg_bank #(.NUM_BYTES(NUM_BYTES), .RST_VAL(RST_VAL)) i_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .cfg_o
  );

  // read slot 0 is the byte count, then stored bytes, then fill
  always_comb begin
    rd_byte = 8'hFF;
    if (idx == '0) rd_byte = 8'(NUM_BYTES);
    for (int k = 0; k < NUM_BYTES; k++)
      if (idx == IW'(k + 1)) rd_byte = cfg_o[8*k +: 8];
  end
endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk
  import cfg_serial_pkg::*;
#(
  parameter int NUM_BYTES = 6,
  localparam int IW = $clog2(NUM_BYTES + 3) + 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   scl_s,
  input logic                   start_evt,
  input logic                   sda_oe_o,
  input logic [NUM_BYTES*8-1:0] cfg_o,
  input logic                   wr_en,
  input logic [IW-1:0]          wr_idx,
  input cfg_st_e                state
);
  assert_idle_released_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE |-> !sda_oe_o);

  assert_drive_on_low_scl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);

  assert_start_releases_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_evt |=> !sda_oe_o);

  assert_cfg_only_by_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> $past(wr_en));

  assert_wr_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> wr_idx < IW'(NUM_BYTES));
endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(.NUM_BYTES(NUM_BYTES)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .start_evt(start_evt),
  .sda_oe_o(sda_oe_o), .cfg_o(cfg_o), .wr_en(wr_en), .wr_idx(wr_idx),
  .state(state)
);

// File: tb/test_cfg_serial_slave.sv
module test_cfg_serial_slave;
  localparam int Q = 20;
  localparam logic [47:0] DEF = 48'hFF_EB_FF_FF_1F_00;

  typedef struct { logic [7:0] val; string tag; } item_t;

  logic clk = 0, rst_n = 0, scl = 1, sda_drv = 1;
  logic sda_oe;
  logic [47:0] cfg;
  wire  sda_line = sda_drv & ~sda_oe;
  int   checks = 0, fails = 0;
  item_t exp_q[$];
  logic [7:0] obs_q[$];
  logic [7:0] model [6];
  logic [7:0] wbuf [10];

  always #2 clk = ~clk;

  cfg_serial_slave i_cfg_serial_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .cfg_o(cfg)
  );

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    wait (obs_q.size() != 0);
    begin
      logic [7:0] a; item_t e;
      a = obs_q.pop_front();
      e = exp_q.pop_front();
      chk(a == e.val, e.tag, 48'(a), 48'(e.val));
    end
  end

  task automatic hold(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_drv = 1; hold(); scl = 1; hold(); sda_drv = 0; hold(); scl = 0; hold();
  endtask
  task automatic bus_stop();
    sda_drv = 0; hold(); scl = 1; hold(); sda_drv = 1; hold();
  endtask
  task automatic bit_out(input logic b);
    sda_drv = b; hold(); scl = 1; hold(); hold(); scl = 0; hold();
  endtask
  task automatic bit_in(output logic b);
    sda_drv = 1; hold(); scl = 1; hold(); b = sda_line; hold(); scl = 0; hold();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    exp_q.push_back('{8'(exp_ack), tag});
    bit_in(a);
    obs_q.push_back(8'(a));
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic nack, input string tag);
    logic [7:0] v;
    exp_q.push_back('{exp, tag});
    for (int i = 7; i >= 0; i--) bit_in(v[i]);
    obs_q.push_back(v);
    bit_out(nack);
  endtask

  function automatic logic [47:0] model_flat();
    logic [47:0] f;
    for (int k = 0; k < 6; k++) f[8*k +: 8] = model[k];
    return f;
  endfunction

  // write frame: address, command, count, n data bytes, stop
  task automatic write_frame(input int n, input bit do_stop);
    bus_start();
    send_byte(8'hD2, 1'b0, "R1 write address ack");
    send_byte(8'h3C, 1'b0, "R3 command ack");
    send_byte(8'h07, 1'b0, "R3 count ack");
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], 1'b0, i < 6 ? "R4 data ack" : "R6 overrun ack");
      if (i < 6) model[i] = wbuf[i];
    end
    if (do_stop) bus_stop();
  endtask

  task automatic read_frame(input int n, input bit with_start);
    if (with_start) bus_start();
    send_byte(8'hD3, 1'b0, "R1 read address ack");
    recv_byte(8'd6, 1'b0, "R7 byte count");
    for (int i = 0; i < n; i++)
      recv_byte(i < 6 ? model[i] : 8'hFF, i == n - 1, i < 6 ? "R7 read data" : "R8 overrun FF");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 6; k++) model[k] = DEF[8*k +: 8];
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(cfg == DEF, "R9 reset bytes", cfg, DEF);
    chk(sda_oe == 1'b0, "R9 line released", 48'(sda_oe), 48'd0);

    // partial write, stop after byte 2
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    write_frame(3, 1);
    chk(cfg == model_flat(), "R5 partial write keeps rest", cfg, model_flat());

    // overrun write
    for (int i = 0; i < 8; i++) wbuf[i] = 8'hA0 + 8'(i);
    write_frame(8, 1);
    chk(cfg == model_flat(), "R6 overrun discarded R4 order", cfg, model_flat());

    // command and count only
    write_frame(0, 1);
    chk(cfg == model_flat(), "R3 dummy bytes no effect", cfg, model_flat());

    // foreign address
    bus_start();
    send_byte(8'hA4, 1'b1, "R2 foreign address nack");
    send_byte(8'h00, 1'b1, "R2 ignored byte");
    send_byte(8'h00, 1'b1, "R2 ignored byte");
    bus_stop();
    chk(cfg == model_flat(), "R2 bytes untouched", cfg, model_flat());

    // long read with overrun, nack on last
    read_frame(8, 1);
    hold();
    chk(sda_oe == 1'b0, "R10 released after nack", 48'(sda_oe), 48'd0);
    bus_stop();

    // short read, nack after byte 0, then released
    read_frame(1, 1);
    hold();
    chk(sda_oe == 1'b0, "R10 short read released", 48'(sda_oe), 48'd0);
    bus_stop();

    // repeated start: write byte 0 then read without stop
    wbuf[0] = 8'h5A;
    write_frame(1, 0);
    read_frame(2, 1);
    bus_stop();
    chk(cfg[7:0] == 8'h5A, "R11 repeated start keeps write", 48'(cfg[7:0]), 48'h5A);

    wait (obs_q.size() == 0);
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule